// File: doc/BRIEF.md
# Local Event and Error Status Register with First-Error Capture

This block collects event and error indications from around a link controller into one 32-bit status word. A companion 32-bit mask word selects which status bits raise the single level-sensitive local interrupt. Hardware sources send one-cycle pulses that set sticky status bits. Firmware clears a sticky bit by writing a one to it through a plain register write and read port.

Some status bits are not stored. Four of them are summaries: each reads as the OR of an external per-function status vector, and it clears only when that vector clears. Two more follow external level inputs: one for a pending link-state transition event and one for a flow-control timeout. The two margining-command error bits also act as valid flags for a shared error-log word. The log captures the command and lane of the first such error and then holds that value until firmware has cleared both of those bits.

The register port needs no handshake. A write takes effect at the clock edge where `reg_wr` is high. Read data is a combinational function of `reg_addr` and the current state.

Top module: `evt_status_unit`

## Requirements
- R1: After reset the status word, the mask word and the log word all read 0. Status bits 9, 10, 15 and 31:18 always read 0.
- R2: A one-cycle pulse on `evt_pulse[i]` sets sticky bit i for i in {4,5,6,7,8,11,12,13,14}, and the bit stays set. Writing 1 to that bit at address 0 clears it. Writing 0 leaves it unchanged. Pulses on any other bit index store nothing.
- R3: `irq` is high exactly when some status bit is 1 while the same bit of the mask word is 0.
- R4: Status bits 0, 1, 2 and 3 read as the OR of `fn_msi_clr`, `fn_msi_set`, `fn_msix_clr` and `fn_msix_set` respectively. Writes to these bits have no effect.
- R5: Status bit 16 reads as `ltssm_pend` and status bit 17 reads as `fc_timeout`. Writes to these bits have no effect.
- R6: An `evt_pulse[4]` that arrives while the log is unlocked loads the log word with {12'b0, `sw_lane`, `sw_cmd`}, so bits 15:0 hold the command and bits 19:16 hold the lane.
- R7: An `evt_pulse[5]` that arrives while the log is unlocked, and without a simultaneous `evt_pulse[4]`, loads the log word with {20'b0, `phy_lane`, `phy_cmd`}, so bits 7:0 hold the command and bits 11:8 hold the lane.
- R8: The log is locked while status bit 4 or bit 5 remains set after that cycle's clear. While it is locked the log word does not change.
- R9: When an event pulse and a write-one-to-clear reach the same sticky bit in the same cycle, the bit ends up set.
- R10: The mask word at address 1 is a plain read/write register that resets to 0.
- R11: Address map: 0 is status, 1 is mask, 2 is the log word, and 3 reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| evt_pulse | input | 32 | One-cycle event pulses, one per status bit index |
| sw_cmd | input | SW_CMD_W (16) | Command that goes with `evt_pulse[4]` |
| sw_lane | input | LANE_W (4) | Lane that goes with `evt_pulse[4]` |
| phy_cmd | input | PHY_CMD_W (8) | Command that goes with `evt_pulse[5]` |
| phy_lane | input | LANE_W (4) | Lane that goes with `evt_pulse[5]` |
| fn_msi_clr | input | NUM_FN | Per-function vector summarised in status bit 0 |
| fn_msi_set | input | NUM_FN | Per-function vector summarised in status bit 1 |
| fn_msix_clr | input | NUM_FN | Per-function vector summarised in status bit 2 |
| fn_msix_set | input | NUM_FN | Per-function vector summarised in status bit 3 |
| ltssm_pend | input | 1 | Link-state transition event pending (status bit 16) |
| fc_timeout | input | 1 | Flow-control timeout flag (status bit 17) |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| irq | output | 1 | Local interrupt, level |

## Verification
The bench builds the block with NUM_FN = 2. At that size the four per-function vectors together hold eight bits, so all 256 combinations of the summary inputs can be driven and compared with bits 0 to 3 and `irq`. The bench also pulses each of the 32 event indices once, and it sweeps every sticky bit against a mask that leaves only that bit open. With the default 16-bit and 8-bit command widths and the 4-bit lane width, the log layouts of R6 and R7 are checked at their real field positions, and the lock is exercised with both logging bits set.

// File: rtl/evt_status_pkg.sv
package evt_status_pkg;
  localparam int REG_W       = 32;
  localparam int BIT_LOG_SW  = 4;
  localparam int BIT_LOG_PHY = 5;
  localparam int BIT_LTSSM   = 16;
  localparam int BIT_FCTO    = 17;
  localparam int NUM_SUMM    = 4;
  // sticky bits: 4..8 and 11..14
  localparam logic [REG_W-1:0] STICKY_MASK = 32'h0000_79F0;
  // bits driven by inputs: 0..3, 16, 17
  localparam logic [REG_W-1:0] LIVE_MASK   = 32'h0003_000F;

  typedef enum logic [1:0] {
    SEL_STATUS = 2'd0,
    SEL_MASK   = 2'd1,
    SEL_LOG    = 2'd2,
    SEL_NONE   = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/sticky_w1c_bank.sv
module sticky_w1c_bank #(
  parameter int W = 32,
  parameter logic [W-1:0] KEEP = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_vec,
  input  logic [W-1:0] clr_vec,
  output logic [W-1:0] q,
  output logic [W-1:0] held
);
  logic [W-1:0] set_eff, clr_eff;

  assign set_eff = set_vec & KEEP;
  assign clr_eff = clr_vec & KEEP;
  assign held    = q & ~clr_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= held | set_eff;
  end

  AST_CLEAR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    ((clr_eff & ~set_eff) != '0) |=> ((q & $past(clr_eff & ~set_eff)) == '0)); // R2
  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    (set_eff != '0) |=> ((q & $past(set_eff)) == $past(set_eff))); // R9
  AST_UNTOUCHED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_eff | clr_eff) == '0) |=> (q == $past(q))); // R2
endmodule

// File: rtl/err_first_log.sv
module err_first_log #(
  parameter int W      = 32,
  parameter int CMDA_W = 16,
  parameter int CMDB_W = 8,
  parameter int LANE_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cap_a,
  input  logic              cap_b,
  input  logic              locked,
  input  logic [CMDA_W-1:0] cmd_a,
  input  logic [LANE_W-1:0] lane_a,
  input  logic [CMDB_W-1:0] cmd_b,
  input  logic [LANE_W-1:0] lane_b,
  output logic [W-1:0]      log_q
);
  localparam int PAD_A = W - CMDA_W - LANE_W;
  localparam int PAD_B = W - CMDB_W - LANE_W;

  logic [W-1:0] word_a, word_b;
  assign word_a = {{PAD_A{1'b0}}, lane_a, cmd_a};
  assign word_b = {{PAD_B{1'b0}}, lane_b, cmd_b};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                log_q <= '0;
    else if (!locked && cap_a) log_q <= word_a;
    else if (!locked && cap_b) log_q <= word_b;
  end

  AST_LOG_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    locked |=> $stable(log_q)); // R8
  AST_LOG_SW_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_a && !locked) |=> (log_q[CMDA_W-1:0] == $past(cmd_a))); // R6
  AST_LOG_PHY_FIELDS: assert property (@(posedge clk) disable iff (!rst_n)
    (cap_b && !cap_a && !locked) |=> (log_q[CMDB_W-1:0] == $past(cmd_b))); // R7
endmodule

// File: rtl/evt_status_unit.sv
module evt_status_unit
  import evt_status_pkg::*;
#(
  parameter int NUM_FN    = 8,
  parameter int SW_CMD_W  = 16,
  parameter int PHY_CMD_W = 8,
  parameter int LANE_W    = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [REG_W-1:0]     evt_pulse,
  input  logic [SW_CMD_W-1:0]  sw_cmd,
  input  logic [LANE_W-1:0]    sw_lane,
  input  logic [PHY_CMD_W-1:0] phy_cmd,
  input  logic [LANE_W-1:0]    phy_lane,
  input  logic [NUM_FN-1:0]    fn_msi_clr,
  input  logic [NUM_FN-1:0]    fn_msi_set,
  input  logic [NUM_FN-1:0]    fn_msix_clr,
  input  logic [NUM_FN-1:0]    fn_msix_set,
  input  logic                 ltssm_pend,
  input  logic                 fc_timeout,
  input  logic                 reg_wr,
  input  logic [1:0]           reg_addr,
  input  logic [REG_W-1:0]     reg_wdata,
  output logic [REG_W-1:0]     reg_rdata,
  output logic                 irq
);
  reg_sel_e               sel;
  logic [REG_W-1:0]       clr_vec, sticky_q, sticky_held, live_bits, status_w;
  logic [REG_W-1:0]       mask_q, log_q;
  logic [NUM_FN-1:0]      fn_all [NUM_SUMM];
  logic                   log_locked;

  assign sel     = reg_sel_e'(reg_addr);
  assign clr_vec = (reg_wr && sel == SEL_STATUS) ? reg_wdata : '0;

  sticky_w1c_bank #(.W(REG_W), .KEEP(STICKY_MASK)) bank_i (
    .clk(clk), .rst_n(rst_n), .set_vec(evt_pulse), .clr_vec(clr_vec),
    .q(sticky_q), .held(sticky_held)
  );

  assign fn_all[0] = fn_msi_clr;
  assign fn_all[1] = fn_msi_set;
  assign fn_all[2] = fn_msix_clr;
  assign fn_all[3] = fn_msix_set;

  always_comb begin
    live_bits = '0;
    live_bits[BIT_LTSSM] = ltssm_pend;
    live_bits[BIT_FCTO]  = fc_timeout;
    for (int g = 0; g < NUM_SUMM; g++) live_bits[g] = |fn_all[g];
  end

  assign status_w = sticky_q | (live_bits & LIVE_MASK);

  // log stays locked while either logging bit survives this cycle's clear
  assign log_locked = sticky_held[BIT_LOG_SW] | sticky_held[BIT_LOG_PHY];

  err_first_log #(.W(REG_W), .CMDA_W(SW_CMD_W), .CMDB_W(PHY_CMD_W), .LANE_W(LANE_W)) log_i (
    .clk(clk), .rst_n(rst_n),
    .cap_a(evt_pulse[BIT_LOG_SW]), .cap_b(evt_pulse[BIT_LOG_PHY]),
    .locked(log_locked),
    .cmd_a(sw_cmd), .lane_a(sw_lane), .cmd_b(phy_cmd), .lane_b(phy_lane),
    .log_q(log_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         mask_q <= '0;
    else if (reg_wr && sel == SEL_MASK) mask_q <= reg_wdata;
  end

  always_comb begin
    case (sel)
      SEL_STATUS: reg_rdata = status_w;
      SEL_MASK:   reg_rdata = mask_q;
      SEL_LOG:    reg_rdata = log_q;
      default:    reg_rdata = '0;
    endcase
  end

  assign irq = |(status_w & ~mask_q);

  AST_MASKED_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_q == '1) |-> !irq); // R3
  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_STATUS) |-> ((reg_rdata & ~(STICKY_MASK | LIVE_MASK)) == '0)); // R1
  AST_SPARE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (sel == SEL_NONE) |-> (reg_rdata == '0)); // R11
endmodule

// File: tb/evt_status_unit_tb_top.sv
module evt_status_unit_tb_top;
  localparam int NF = 2;
  localparam logic [31:0] STK = 32'h0000_79F0;

  logic clk = 0, rst_n = 0;
  logic [31:0] evt_pulse = '0, reg_wdata = '0, reg_rdata;
  logic [15:0] sw_cmd = '0;
  logic [7:0]  phy_cmd = '0;
  logic [3:0]  sw_lane = '0, phy_lane = '0;
  logic [NF-1:0] fa = '0, fb = '0, fc = '0, fd = '0;
  logic ltssm_pend = 0, fc_timeout = 0, reg_wr = 0, irq;
  logic [1:0] reg_addr = '0;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  evt_status_unit #(.NUM_FN(NF)) dut_i (
    .clk(clk), .rst_n(rst_n), .evt_pulse(evt_pulse), .sw_cmd(sw_cmd), .sw_lane(sw_lane),
    .phy_cmd(phy_cmd), .phy_lane(phy_lane), .fn_msi_clr(fa), .fn_msi_set(fb),
    .fn_msix_clr(fc), .fn_msix_set(fd), .ltssm_pend(ltssm_pend), .fc_timeout(fc_timeout),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq(irq)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0; reg_wdata = '0;
  endtask

  task automatic pulse(input logic [31:0] v);
    @(negedge clk); evt_pulse = v;
    @(negedge clk); evt_pulse = '0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d, e;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 R10 reset values
    rd(0, d); chk("R1 status reset", d, 0);
    rd(1, d); chk("R10 mask reset", d, 0);
    rd(2, d); chk("R1 log reset", d, 0);
    chk("R3 irq idle", {31'b0, irq}, 0);

    // R2 R1: pulse every index, write 0 then 1
    for (int i = 0; i < 32; i++) begin
      e = STK & (32'h1 << i);
      pulse(32'h1 << i);
      rd(0, d); chk("R2 set/R1 rsvd", d, e);
      chk("R3 irq follows", {31'b0, irq}, {31'b0, e != 0});
      wr(0, 32'h0);
      rd(0, d); chk("R2 write0 keeps", d, e);
      wr(0, 32'h1 << i);
      rd(0, d); chk("R2 write1 clears", d, 0);
    end

    // R4 exhaustive summary inputs
    for (int v = 0; v < 256; v++) begin
      @(negedge clk);
      {fd, fc, fb, fa} = v[7:0];
      e = {28'b0, |fd, |fc, |fb, |fa};
      if (v == 255) wr(0, 32'hFFFF_FFFF);
      rd(0, d); chk("R4 summary", d, e);
      chk("R3 summary irq", {31'b0, irq}, {31'b0, e != 0});
    end
    @(negedge clk); {fd, fc, fb, fa} = '0;

    // R5 level-following bits
    for (int v = 0; v < 4; v++) begin
      @(negedge clk); {fc_timeout, ltssm_pend} = v[1:0];
      wr(0, 32'h0003_0000);
      rd(0, d); chk("R5 follow", d, {14'b0, v[1:0], 16'b0});
    end
    @(negedge clk); {fc_timeout, ltssm_pend} = '0;

    // R3 mask sweep with all sticky bits set
    pulse(STK);
    for (int k = 0; k < 32; k++) begin
      if (STK[k]) begin
        wr(1, ~(32'h1 << k));
        rd(0, d); chk("R3 single open", {31'b0, irq}, 1);
      end
    end
    wr(1, 32'hFFFF_FFFF);
    rd(0, d); chk("R3 all masked", {31'b0, irq}, 0);
    wr(1, 32'hA5C3_0F96); rd(1, d); chk("R10 mask rw", d, 32'hA5C3_0F96);
    wr(1, 32'h0); rd(1, d); chk("R10 mask zero", d, 0);
    wr(0, 32'hFFFF_FFFF);
    rd(0, d); chk("R2 clear all", d, 0);

    // R6 R8 R7 log capture and lock
    @(negedge clk); sw_cmd = 16'hBEEF; sw_lane = 4'h5;
    pulse(32'h10);
    rd(2, d); chk("R6 sw log", d, 32'h0005_BEEF);
    @(negedge clk); sw_cmd = 16'h1234; sw_lane = 4'hA; phy_cmd = 8'h3C; phy_lane = 4'h9;
    pulse(32'h10); rd(2, d); chk("R8 locked by sw", d, 32'h0005_BEEF);
    pulse(32'h20); rd(2, d); chk("R8 locked again", d, 32'h0005_BEEF);
    wr(0, 32'h10);
    pulse(32'h20); rd(2, d); chk("R8 phy bit holds lock", d, 32'h0005_BEEF);
    wr(0, 32'h20);
    pulse(32'h20); rd(2, d); chk("R7 phy log", d, 32'h0000_093C);
    wr(0, 32'h30);

    // R9 set wins over simultaneous clear
    @(negedge clk); evt_pulse = 32'h80; reg_wr = 1; reg_addr = 0; reg_wdata = 32'h80;
    @(negedge clk); evt_pulse = '0; reg_wr = 0; reg_wdata = '0;
    rd(0, d); chk("R9 set wins", d, 32'h80);
    wr(0, 32'h80);

    // R11 spare address
    wr(3, 32'hFFFF_FFFF);
    rd(3, d); chk("R11 spare reads 0", d, 0);
    rd(1, d); chk("R11 spare write no effect", d, 0);

    done = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule